// File: doc/BRIEF.md
# DMA Descriptor-Chain Error Handler

This block is the sequencing and error-reaction core of one chained-descriptor DMA channel. Software arms the channel by writing its enable bit. The channel then fetches a descriptor and runs its transfer. Depending on the descriptor, it writes a status word back. It then moves on to the next descriptor or finishes the chain. Data movement, address generation and the real bus protocol sit outside the block. They are represented by request/acknowledge pairs: descriptor fetch, transfer and status write-back.

The bus side reports five error pulses: interface parity, master-abort, target-abort, memory-port abort and zero-result buffer. The first four always halt the channel. The zero-result error halts the channel only when the current descriptor has status write-back disabled. Otherwise it is recorded in the written-back status and the chain carries on. A halt records sticky flags in a status word, drops the active and enable bits and pulses an interrupt. The channel then stays halted until software clears the flags and writes the enable bit again.

The state machine has six states: IDLE, FETCH, TRANSFER, WRITEBACK, NEXT and HALTED. Its transitions are:
- IDLE to FETCH on an enable write, or with enable set and no flags.
- FETCH to TRANSFER on fetch acknowledge.
- TRANSFER to WRITEBACK on transfer done with write-back enabled, or on a non-fatal zero-result error.
- TRANSFER to NEXT on transfer done with write-back disabled.
- WRITEBACK to NEXT on write-back acknowledge.
- NEXT to FETCH when more descriptors follow.
- NEXT to IDLE at the end of the chain.
- Any of FETCH, TRANSFER, WRITEBACK or NEXT to HALTED on a fatal error.
- HALTED to IDLE once all flags read zero.

Top module: `dma_err_seq`

## Requirements
- R1: After reset, `status_o` is 0 (not active, not enabled, no flags), and `irq_o`, `fetch_req_o`, `xfer_req_o` and `wb_req_o` are low.
- R2: A one-cycle `en_set_i` pulse in IDLE with no flags set raises `fetch_req_o` and sets status bit 1 (enable) and bit 0 (active) at the next clock edge.
- R3: A parity (`err_i[0]`), master-abort (`err_i[1]`), target-abort (`err_i[2]`) or memory-port abort (`err_i[3]`) pulse in FETCH, TRANSFER, WRITEBACK or NEXT is fatal. At the next edge the channel sets the status flag, using bit 2 for parity, bit 5 for master-abort, bit 3 for target-abort and bit 4 for memory-port abort. At the same edge it clears status bits 1:0, drops all requests and raises `irq_o`.
- R4: While halted, `fetch_req_o` stays low, even if the enable bit has been written again, for as long as any flag remains set.
- R5: A zero-result pulse (`err_i[4]`) in TRANSFER, when the descriptor's write-back enable is clear, is fatal in the same way as R3 and sets status bit 6.
- R6: A zero-result pulse in TRANSFER, when write-back is enabled, is non-fatal. At the next edge `wb_req_o` rises with `wb_status_o` = 2'b11 (bit 0 transfer complete, bit 1 zero-result error), no flag is set and `irq_o` stays low.
- R7: A transfer that completes with write-back enabled and no error raises `wb_req_o` with `wb_status_o` = 2'b01 at the edge that samples `xfer_done_i`.
- R8: After a descriptor ends (write-back acknowledged, or transfer done without write-back), the channel passes through NEXT for one cycle. It then raises `fetch_req_o` if the descriptor was not the last. If it was the last, it returns to IDLE with status bits 1:0 cleared and no interrupt.
- R9: Several error pulses in one cycle set all of their flags, and `irq_o` is high for exactly one cycle.
- R10: Flags are write-1-to-clear through `err_clr_i`, which uses the same bit order as `err_i`. Clearing a flag that is not set changes nothing. When the last flag clears, HALTED moves to IDLE on the following edge. If the enable bit is set, FETCH follows on the edge after that.
- R11: Error pulses are ignored in IDLE and HALTED, and a zero-result pulse outside TRANSFER is ignored. In these cases `status_o` is unchanged and `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set_i | input | 1 | Software write of 1 to the enable bit |
| err_clr_i | input | 5 | Write-1-to-clear mask for the error flags (order as err_i) |
| err_i | input | 5 | Error pulses: 0 parity, 1 master-abort, 2 target-abort, 3 memory-port abort, 4 zero-result |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_ack_i | input | 1 | Descriptor fetched; qualifies desc_wb_en_i and desc_last_i |
| desc_wb_en_i | input | 1 | Status write-back enable of the fetched descriptor |
| desc_last_i | input | 1 | Fetched descriptor is the last of the chain |
| xfer_req_o | output | 1 | Transfer request for the current descriptor |
| xfer_done_i | input | 1 | Transfer finished |
| wb_req_o | output | 1 | Status write-back request |
| wb_status_o | output | 2 | Written-back status: bit 0 complete, bit 1 zero-result error |
| wb_ack_i | input | 1 | Write-back accepted |
| irq_o | output | 1 | One-cycle interrupt pulse on a fatal error |
| status_o | output | 7 | 0 active, 1 enable, 2 parity, 3 target-abort, 4 memory-port, 5 master-abort, 6 zero-result |

## Verification
Every input is sampled by exactly one register stage, so every result is due at the first clock edge after its stimulus. This covers the flags, the halt, the interrupt, the write-back request and the next fetch. The one exception is the path out of HALTED after a clear, which needs two further edges (HALTED to IDLE, then IDLE to FETCH). The bench drives inputs just after a falling edge, holds each pulse across one rising edge, and samples at the next falling edge. It steps one extra edge wherever NEXT or the halt exit adds a cycle. The one-cycle interrupt width is confirmed by sampling again one edge later.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
    localparam int NUM_ERR = 5;
    localparam int ERR_PAR = 0;
    localparam int ERR_MAB = 1;
    localparam int ERR_TAB = 2;
    localparam int ERR_MPA = 3;
    localparam int ERR_ZRB = 4;
    localparam int STAT_W  = NUM_ERR + 2;
    localparam int WBS_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_WBACK,
        ST_NEXT,
        ST_HALT
    } dma_st_e;
endpackage

// File: rtl/dma_err_classify.sv
module dma_err_classify
    import dma_err_pkg::*;
(
    input  logic [NUM_ERR-1:0] err_i,
    input  logic               active_i,
    input  logic               in_xfer_i,
    input  logic               wb_en_i,
    output logic [NUM_ERR-1:0] rec_o,
    output logic               fatal_o,
    output logic               nonfatal_o
);
    logic zero_hit;

    for (genvar g = 0; g < ERR_ZRB; g++) begin : g_hard
        assign rec_o[g] = err_i[g] & active_i;
    end

    assign zero_hit       = err_i[ERR_ZRB] & in_xfer_i;
    assign rec_o[ERR_ZRB] = zero_hit & ~wb_en_i;
    assign fatal_o        = |rec_o;
    assign nonfatal_o     = zero_hit & wb_en_i & ~fatal_o;
endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags #(
    parameter int NERR = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] set_i,
    input  logic [NERR-1:0] clr_i,
    output logic [NERR-1:0] flags_o,
    output logic            zero_o
);
    logic [NERR-1:0] flags_q;

    for (genvar g = 0; g < NERR; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)        flags_q[g] <= 1'b0;
            else if (set_i[g]) flags_q[g] <= 1'b1;
            else if (clr_i[g]) flags_q[g] <= 1'b0;
        end

        // R10
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flags_q[g]);

        // R3
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g] && !clr_i[g]) |=> flags_q[g]);
    end

    assign flags_o = flags_q;
    assign zero_o  = ~|flags_q;
endmodule

// File: rtl/dma_err_fsm.sv
module dma_err_fsm
    import dma_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set_i,
    input  logic             flags_zero_i,
    input  logic             fatal_i,
    input  logic             nonfatal_i,
    input  logic             fetch_ack_i,
    input  logic             desc_wb_en_i,
    input  logic             desc_last_i,
    input  logic             xfer_done_i,
    input  logic             wb_ack_i,
    output logic             fetch_req_o,
    output logic             xfer_req_o,
    output logic             wb_req_o,
    output logic [WBS_W-1:0] wb_status_o,
    output logic             irq_o,
    output logic             en_o,
    output logic             active_o,
    output logic             in_xfer_o,
    output logic             wb_en_o
);
    dma_st_e state_q, state_d;
    logic    en_q, wb_en_q, last_q, zerr_q, irq_q;
    logic    chain_end;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if ((en_q || en_set_i) && flags_zero_i) state_d = ST_FETCH;
            ST_FETCH: if (fatal_i)          state_d = ST_HALT;
                      else if (fetch_ack_i) state_d = ST_XFER;
            ST_XFER:  if (fatal_i)          state_d = ST_HALT;
                      else if (nonfatal_i)  state_d = ST_WBACK;
                      else if (xfer_done_i) state_d = wb_en_q ? ST_WBACK : ST_NEXT;
            ST_WBACK: if (fatal_i)          state_d = ST_HALT;
                      else if (wb_ack_i)    state_d = ST_NEXT;
            ST_NEXT:  if (fatal_i)          state_d = ST_HALT;
                      else                  state_d = last_q ? ST_IDLE : ST_FETCH;
            ST_HALT:  if (flags_zero_i)     state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    assign chain_end = (state_q == ST_NEXT) && last_q && !fatal_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            wb_en_q <= 1'b0;
            last_q  <= 1'b0;
            zerr_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= fatal_i;
            if (fatal_i)        en_q <= 1'b0;
            else if (en_set_i)  en_q <= 1'b1;
            else if (chain_end) en_q <= 1'b0;
            if (state_q == ST_FETCH && fetch_ack_i) begin
                wb_en_q <= desc_wb_en_i;
                last_q  <= desc_last_i;
                zerr_q  <= 1'b0;
            end else if (nonfatal_i) begin
                zerr_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        fetch_req_o = 1'b0;
        xfer_req_o  = 1'b0;
        wb_req_o    = 1'b0;
        active_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin fetch_req_o = 1'b1; active_o = 1'b1; end
            ST_XFER:  begin xfer_req_o  = 1'b1; active_o = 1'b1; end
            ST_WBACK: begin wb_req_o    = 1'b1; active_o = 1'b1; end
            ST_NEXT:  active_o = 1'b1;
            ST_HALT:  ;
            default:  ;
        endcase
    end

    assign wb_status_o = {zerr_q, 1'b1};
    assign irq_o       = irq_q;
    assign en_o        = en_q;
    assign in_xfer_o   = (state_q == ST_XFER);
    assign wb_en_o     = wb_en_q;

    // R3
    halt_on_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_i |=> (state_q == ST_HALT && !en_q && irq_q));

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R4
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !flags_zero_i) |=> !fetch_req_o);

    // R6
    nonfatal_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nonfatal_i |=> (wb_req_o && wb_status_o == 2'b11 && !irq_q));
endmodule

// File: rtl/dma_err_seq.sv
module dma_err_seq
    import dma_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_set_i,
    input  logic [NUM_ERR-1:0] err_clr_i,
    input  logic [NUM_ERR-1:0] err_i,
    output logic               fetch_req_o,
    input  logic               fetch_ack_i,
    input  logic               desc_wb_en_i,
    input  logic               desc_last_i,
    output logic               xfer_req_o,
    input  logic               xfer_done_i,
    output logic               wb_req_o,
    output logic [WBS_W-1:0]   wb_status_o,
    input  logic               wb_ack_i,
    output logic               irq_o,
    output logic [STAT_W-1:0]  status_o
);
    logic [NUM_ERR-1:0] rec, flags;
    logic               fatal, nonfatal, flags_zero;
    logic               en, active, in_xfer, wb_en;

    dma_err_classify u_cls (
        .err_i      (err_i),
        .active_i   (active),
        .in_xfer_i  (in_xfer),
        .wb_en_i    (wb_en),
        .rec_o      (rec),
        .fatal_o    (fatal),
        .nonfatal_o (nonfatal)
    );

    dma_err_flags #(.NERR(NUM_ERR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (rec),
        .clr_i   (err_clr_i),
        .flags_o (flags),
        .zero_o  (flags_zero)
    );

    dma_err_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_set_i     (en_set_i),
        .flags_zero_i (flags_zero),
        .fatal_i      (fatal),
        .nonfatal_i   (nonfatal),
        .fetch_ack_i  (fetch_ack_i),
        .desc_wb_en_i (desc_wb_en_i),
        .desc_last_i  (desc_last_i),
        .xfer_done_i  (xfer_done_i),
        .wb_ack_i     (wb_ack_i),
        .fetch_req_o  (fetch_req_o),
        .xfer_req_o   (xfer_req_o),
        .wb_req_o     (wb_req_o),
        .wb_status_o  (wb_status_o),
        .irq_o        (irq_o),
        .en_o         (en),
        .active_o     (active),
        .in_xfer_o    (in_xfer),
        .wb_en_o      (wb_en)
    );

    assign status_o = {flags[ERR_ZRB], flags[ERR_MAB], flags[ERR_MPA],
                       flags[ERR_TAB], flags[ERR_PAR], en, active};

    // R11
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && flags_zero) |=> !irq_o);
endmodule

// File: tb/dma_err_seq_tb.sv
`timescale 1ns/1ps
module dma_err_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_set = 1'b0;
    logic [4:0] err_clr = '0;
    logic [4:0] err = '0;
    logic       fetch_req, fetch_ack = 1'b0, desc_wb = 1'b0, desc_last = 1'b0;
    logic       xfer_req, xfer_done = 1'b0, wb_req, wb_ack = 1'b0, irq;
    logic [1:0] wb_status;
    logic [6:0] status;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    dma_err_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en_set_i(en_set), .err_clr_i(err_clr),
        .err_i(err), .fetch_req_o(fetch_req), .fetch_ack_i(fetch_ack),
        .desc_wb_en_i(desc_wb), .desc_last_i(desc_last), .xfer_req_o(xfer_req),
        .xfer_done_i(xfer_done), .wb_req_o(wb_req), .wb_status_o(wb_status),
        .wb_ack_i(wb_ack), .irq_o(irq), .status_o(status)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic start();
        en_set = 1'b1; step(); en_set = 1'b0;
    endtask

    task automatic fetch(input logic wb, input logic last);
        fetch_ack = 1'b1; desc_wb = wb; desc_last = last; step();
        fetch_ack = 1'b0; desc_wb = 1'b0; desc_last = 1'b0;
    endtask

    task automatic clear_all();
        err_clr = 5'h1f; step(); err_clr = '0; step(); step();
    endtask

    // err[15:11] wb[10] halt[9] status[8:2] wb_status[1:0]
    localparam logic [15:0] VEC [8] = '{
        {5'b00001, 1'b0, 1'b1, 7'h04, 2'b00},
        {5'b00010, 1'b0, 1'b1, 7'h20, 2'b00},
        {5'b00100, 1'b1, 1'b1, 7'h08, 2'b00},
        {5'b01000, 1'b0, 1'b1, 7'h10, 2'b00},
        {5'b10000, 1'b0, 1'b1, 7'h40, 2'b00},
        {5'b10000, 1'b1, 1'b0, 7'h03, 2'b11},
        {5'b00011, 1'b0, 1'b1, 7'h24, 2'b00},
        {5'b00000, 1'b1, 1'b0, 7'h03, 2'b01}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1; step();
        chk("R1 status", {1'b0, status}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 reqs", {5'd0, fetch_req, xfer_req, wb_req}, 8'h00);

        err = 5'h1f; step(); err = '0;
        chk("R11 idle err status", {1'b0, status}, 8'h00);
        chk("R11 idle err irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < 8; i++) begin
            logic [4:0] e;
            logic       wb, halt;
            logic [6:0] st;
            logic [1:0] ws;
            string      tag;
            {e, wb, halt, st, ws} = VEC[i];
            if (e == 5'b10000) tag = wb ? "R6" : "R5";
            else if (e == 5'b0) tag = "R7";
            else if ($countones(e) > 1) tag = "R9";
            else tag = "R3";
            clear_all();
            start();
            chk("R2 fetch_req", {7'd0, fetch_req}, 8'h01);
            chk("R2 status", {1'b0, status}, 8'h03);
            fetch(wb, 1'b1);
            chk({tag, " xfer_req"}, {7'd0, xfer_req}, 8'h01);
            if (e == 5'b0) xfer_done = 1'b1; else err = e;
            step();
            xfer_done = 1'b0; err = '0;
            chk({tag, " status"}, {1'b0, status}, {1'b0, st});
            chk({tag, " irq"}, {7'd0, irq}, {7'd0, halt});
            chk({tag, " wb_req"}, {7'd0, wb_req}, {7'd0, !halt});
            if (!halt) begin
                chk({tag, " wb_status"}, {6'd0, wb_status}, {6'd0, ws});
                wb_ack = 1'b1; step(); wb_ack = 1'b0;
                step();
                chk("R8 chain end status", {1'b0, status}, 8'h00);
                chk("R8 chain end irq", {7'd0, irq}, 8'h00);
            end else begin
                step();
                chk("R9 irq one cycle", {7'd0, irq}, 8'h00);
                step(); step();
                chk("R4 no fetch halted", {7'd0, fetch_req}, 8'h00);
                err = 5'h1f; step(); err = '0;
                chk("R11 halted err status", {1'b0, status}, {1'b0, st});
            end
        end

        clear_all();
        start();
        fetch(1'b0, 1'b0);
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        chk("R8 next state quiet", {4'd0, fetch_req, xfer_req, wb_req, status[0]}, 8'h01);
        step();
        chk("R8 refetch", {7'd0, fetch_req}, 8'h01);
        err = 5'b10000; step(); err = '0;
        chk("R11 zero in fetch status", {1'b0, status}, 8'h03);
        chk("R11 zero in fetch req", {7'd0, fetch_req}, 8'h01);
        fetch(1'b0, 1'b1);
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        step();
        chk("R8 last idle", {1'b0, status}, 8'h00);

        start();
        err = 5'b00100; step(); err = '0;
        chk("R3 fatal in fetch", {1'b0, status}, 8'h08);
        start();
        chk("R4 enable while flagged", {1'b0, status}, 8'h0a);
        step(); step();
        chk("R4 stays halted", {7'd0, fetch_req}, 8'h00);
        err_clr = 5'b00001; step(); err_clr = '0;
        chk("R10 clear unset flag", {1'b0, status}, 8'h0a);
        err_clr = 5'b00100; step(); err_clr = '0;
        chk("R10 flag cleared", {1'b0, status}, 8'h02);
        chk("R10 no fetch yet", {7'd0, fetch_req}, 8'h00);
        step();
        chk("R10 idle no fetch", {7'd0, fetch_req}, 8'h00);
        step();
        chk("R10 restart fetch", {7'd0, fetch_req}, 8'h01);
        chk("R10 restart status", {1'b0, status}, 8'h03);

        summary();
        $finish;
    end
endmodule